// File: doc/BRIEF.md
# Low-Order Interleaved Block Memory

This block is a four-bank word store that answers cache block refills and block write-backs over a one-word return path. A requester presents one block address. The block sends that address to every bank in the same cycle. All banks then perform their long access side by side, so the access latency is paid once for the whole block instead of once per word.

For a read, the words of the block come back one per cycle, lowest word first. Each returned word carries a valid strobe, and a completion pulse marks the last word. For a write, all four words of the supplied block are stored together once the access latency has passed. A completion pulse then follows. While a transfer is running, the block raises a busy flag and ignores any new request.

Top module: `ilv_blockmem`

## Requirements
- R1: After reset, `busy`, `rd_valid` and `done` are low, and `rd_data` is zero.
- R2: A request is taken on a rising edge where `req_valid` is high and `busy` is low. `busy` goes high in the cycle after that edge and stays high until the transfer ends.
- R3: For a read, `rd_valid` is first high in cycle 1+LAT after the accepting edge, where cycle 0 is the cycle just after that edge. It then stays high for exactly four consecutive cycles. With the default LAT of 15, the valid cycles are cycles 16 to 19.
- R4: Word k of the block, for k from 0 to 3, sits in bank k. Its word address is 4*block+k, so the two low-order word-address bits name the bank. Words are returned in the order k = 0, 1, 2, 3. Write data lane k is `req_wdata[32k+31:32k]`.
- R5: On a read, `done` is high only in the cycle of the fourth word. `busy` is low in the next cycle, so a read occupies 1+LAT+4 = 20 cycles.
- R6: On a write, all four words are stored. `done` is high for one cycle at cycle 1+LAT, `rd_valid` stays low throughout, and `busy` is low in the cycle after `done`.
- R7: A request presented while `busy` is high is ignored. It causes no extra transfer, changes no stored word, and does not alter the data returned by the transfer in progress.
- R8: `rd_data` is zero whenever `rd_valid` is low.
- R9: A write to one block leaves every other block unchanged. This holds for the lowest and highest block addresses as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = block write, 0 = block read |
| req_addr | input | AW | Block address |
| req_wdata | input | BANKS*DW | Block write data; lane k goes to bank k |
| busy | output | 1 | A transfer is in progress |
| rd_valid | output | 1 | `rd_data` holds a returned word |
| rd_data | output | DW | Returned word, zero when not valid |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong internal state shows up at the ports in one of three ways.

A miscounted latency counter moves the first `rd_valid` or the write `done` away from cycle 16. That error is visible on the first transfer.

A wrong word index or a bad bank-select lane shows as swapped or repeated words within one read burst. It appears within the four return cycles.

A request that is accepted while busy, or a write that lands in the wrong bank row, does not show during the current transfer. It appears as corrupted data on the next read of the affected block. The bench therefore reads the target block again after every such stimulus.

// File: rtl/ilv_blockmem.sv
module ilv_blockmem #(
  parameter int DW    = 32,
  parameter int AW    = 6,
  parameter int LAT   = 15,
  parameter int BANKS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [AW-1:0]         req_addr,
  input  logic [BANKS*DW-1:0]   req_wdata,
  output logic                  busy,
  output logic                  rd_valid,
  output logic [DW-1:0]         rd_data,
  output logic                  done
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = (LAT > 1) ? $clog2(LAT + 1) : 1;
  localparam int IW    = (BANKS > 1) ? $clog2(BANKS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACC, S_RET, S_WDONE} st_t;

  st_t                st;
  logic [AW-1:0]      addr_q;
  logic               wr_q;
  logic [BANKS*DW-1:0] wdata_q;
  logic [CW-1:0]      cnt;
  logic [IW-1:0]      widx;
  logic [BANKS*DW-1:0] hold_flat;

  wire accept   = (st == S_IDLE) && req_valid;
  wire acc_last = (st == S_ACC) && (cnt == '0);
  wire last_w   = (widx == IW'(BANKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      cnt     <= '0;
      widx    <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st      <= S_ADDR;
          addr_q  <= req_addr;
          wr_q    <= req_write;
          wdata_q <= req_wdata;
        end
        S_ADDR: begin
          st  <= S_ACC;
          cnt <= CW'(LAT - 1);
        end
        S_ACC: begin
          if (cnt == '0) begin
            st   <= wr_q ? S_WDONE : S_RET;
            widx <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_RET: begin
          if (last_w) st <= S_IDLE;
          else        widx <= widx + 1'b1;
        end
        S_WDONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] hold;
    always_ff @(posedge clk) begin
      if (acc_last) begin
        if (wr_q) mem[addr_q] <= wdata_q[b*DW +: DW];
        else      hold        <= mem[addr_q];
      end
    end
    assign hold_flat[b*DW +: DW] = hold;
  end

  assign busy     = (st != S_IDLE);
  assign rd_valid = (st == S_RET);
  assign rd_data  = rd_valid ? hold_flat[widx*DW +: DW] : '0;
  assign done     = (st == S_WDONE) || (rd_valid && last_w);
endmodule

// File: rtl/ilv_blockmem_chk.sv
module ilv_blockmem_chk #(
  parameter int DW  = 32,
  parameter int LAT = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          done
);
  logic [15:0] bcyc;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) bcyc <= '0;
    else if (bcyc != 16'hFFFF) bcyc <= bcyc + 1'b1;
  end

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R3
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  // R3
  first_word_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> bcyc == 16'(LAT + 1));

  // R3
  burst_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !done) |=> rd_valid);

  // R5
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R5
  read_done_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_valid) |-> bcyc == 16'(LAT + 4));

  // R6
  write_done_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rd_valid) |-> bcyc == 16'(LAT + 1));

  // R8
  quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0);
endmodule

bind ilv_blockmem ilv_blockmem_chk #(.DW(DW), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
);

// File: tb/ilv_blockmem_test.sv
module ilv_blockmem_test;
  localparam int DW = 32, AW = 6, LAT = 15, BANKS = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [BANKS*DW-1:0] req_wdata = '0;
  logic busy, rd_valid, done;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] model [1<<AW][BANKS];

  always #2 clk = ~clk;

  ilv_blockmem #(.DW(DW), .AW(AW), .LAT(LAT), .BANKS(BANKS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int blk, input int k, input int seed);
    return DW'(32'hA5000000 ^ (seed << 16) ^ (blk << 4) ^ k);
  endfunction

  // Issue a request; after return, the caller is at the negedge of cycle 0.
  task automatic issue(input bit wr, input int blk, input logic [BANKS*DW-1:0] wd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = AW'(blk); req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic inject(input int c, input int inj_c, input int inj_blk, input bit inj_wr);
    if (c == inj_c) begin
      req_valid = 1; req_write = inj_wr; req_addr = AW'(inj_blk);
      req_wdata = {BANKS*DW/32{32'hDEADBEEF}};
    end else begin
      req_valid = 0;
    end
  endtask

  task automatic write_block(input int blk, input int seed, input int inj_c, input int inj_blk);
    logic [BANKS*DW-1:0] wd;
    for (int k = 0; k < BANKS; k++) wd[k*DW +: DW] = pat(blk, k, seed);
    issue(1, blk, wd);
    for (int c = 0; c <= LAT + 4; c++) begin
      if (c > 0) @(negedge clk);
      if (c <= LAT + 1) chk(busy == 1, "R2 busy during write", busy, 1);
      else              chk(busy == 0, "R6 idle after write", busy, 0);
      chk(done == (c == LAT + 1), "R6 write done timing", done, c == LAT + 1);
      chk(rd_valid == 0, "R6 no rd_valid on write", rd_valid, 0);
      chk(rd_data == 0, "R8 data quiet", rd_data, 0);
      inject(c, inj_c, inj_blk, 0);
    end
    req_valid = 0;
    for (int k = 0; k < BANKS; k++) model[blk][k] = pat(blk, k, seed);
  endtask

  task automatic read_block(input int blk, input int inj_c, input int inj_blk);
    issue(0, blk, '0);
    for (int c = 0; c <= LAT + 6; c++) begin
      if (c > 0) @(negedge clk);
      if (c <= LAT + 4) chk(busy == 1, "R2 busy during read", busy, 1);
      else              chk(busy == 0, "R5 idle after read", busy, 0);
      if (c >= LAT + 1 && c <= LAT + 4) begin
        chk(rd_valid == 1, "R3 rd_valid window", rd_valid, 1);
        chk(rd_data == model[blk][c-LAT-1], "R4 word order/data", rd_data, model[blk][c-LAT-1]);
      end else begin
        chk(rd_valid == 0, "R3 rd_valid outside window", rd_valid, 0);
        chk(rd_data == 0, "R8 data quiet", rd_data, 0);
      end
      chk(done == (c == LAT + 4), "R5 read done timing", done, c == LAT + 4);
      inject(c, inj_c, inj_blk, 1);
    end
    req_valid = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(busy == 0, "R1 busy reset", busy, 0);
    chk(rd_valid == 0, "R1 rd_valid reset", rd_valid, 0);
    chk(done == 0, "R1 done reset", done, 0);
    chk(rd_data == 0, "R1 rd_data reset", rd_data, 0);

    write_block(5, 1, -1, 0);
    read_block(5, -1, 0);
    // R9 boundary blocks, block 5 unaffected
    write_block(0, 2, -1, 0);
    write_block(63, 3, -1, 0);
    read_block(0, -1, 0);
    read_block(63, -1, 0);
    read_block(5, -1, 0);
    // R7 write request during a read is ignored
    read_block(5, 3, 5);
    read_block(5, -1, 0);
    // R7 requests during a write are ignored (extra read, extra write)
    write_block(6, 4, 10, 5);
    read_block(6, -1, 0);
    read_block(5, 18, 6);
    read_block(6, -1, 0);
    // R7 no extra transfer follows the ignored request
    repeat (4) begin
      @(negedge clk);
      chk(busy == 0, "R7 no extra transfer", busy, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule